// File: doc/BRIEF.md
# Multi-mode iterative CORDIC engine

This block computes trigonometric and linear functions in fixed point. It performs one shift-and-add micro-rotation per clock. One datapath serves five operations: circular rotation, circular vectoring, linear rotation (multiply-accumulate), linear vectoring (divide-accumulate) and arcsine. For arcsine, each step compares the running y value against a reference input. The caller loads x, y, z and the reference with a start strobe. After a fixed number of cycles the engine returns the final x, y and z and raises a one-cycle completion pulse.

The x, y and reference values share one radix alignment because every step cross-adds shifted copies of x into y and back. In the default build this alignment is two's complement with 13 fraction bits, so one unit is 8192. The angle accumulator z has its own width and fraction-bit parameters. In circular modes z is in radians with 13 fraction bits by default. z touches the rotator only through the per-step direction decision. The circular gain K = ∏ sqrt(1 + 2^-2i), which is about 1.64676 for 16 steps, is not removed inside the block. The caller pre-scales x (and y) by 1/K, which is about 0.60725 (4975 counts), when unit-gain results are wanted. The step constants are computed when the block is elaborated: atan(2^-i) for circular modes and 2^-i for linear modes.

Top module: `cordic_engine`

## Requirements
- R1: While reset is asserted and after it is released, busy and done are 0 and x_o, y_o and z_o read 0.
- R2: A start sampled at a rising edge while busy is 0 is accepted: busy goes to 1 after that edge. At the ITER-th rising edge after the accepting edge (ITER = 16 by default), busy returns to 0 and done is 1 for exactly one cycle.
- R3: A start sampled while busy is 1 has no effect: the running operation keeps its inputs, its results and its completion time.
- R4: From the done pulse until the next accepted start, x_o, y_o and z_o hold their values.
- R5: Mode code 00 (circular rotation) returns x = K(x0 cos z0 − y0 sin z0) and y = K(x0 sin z0 + y0 cos z0), with z driven to about 0, for |z0| ≤ 1.7 rad. Each result is within 32 LSB.
- R6: Mode code 01 (circular vectoring, x0 > 0) returns z = z0 + atan(y0/x0) and x = K·sqrt(x0² + y0²), with y driven to about 0. Each result is within 32 LSB.
- R7: Mode code 10 with lin_vec = 0 (linear rotation) returns y = y0 + x0·z0 within 32 LSB, with z driven to about 0. x stays unchanged on every cycle of the run. Valid results need |z0| < 2.
- R8: Mode code 10 with lin_vec = 1 (linear vectoring, x0 > 0) returns z = z0 + y0/x0 within 32 LSB, with y driven to about 0. Valid results need |y0/x0| < 2.
- R9: Mode code 11 (arcsine) with x0 = 1/K and y0 = 0 returns z = z0 + asin(c) within 96 LSB, for |c| ≤ 0.8. A reference of +0.5 gives +π/6, not −π/6.
- R10: lin_vec has no effect in mode codes 00, 01 and 11: the results are bit-identical to a run with lin_vec = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to load operands and begin; honoured only while idle |
| mode_i | input | 2 | Operation code: 00 circular rotation, 01 circular vectoring, 10 linear, 11 arcsine |
| lin_vec_i | input | 1 | In mode 10: 0 selects rotation, 1 selects vectoring |
| x_i | input | DW | Initial x, signed, XYF fraction bits |
| y_i | input | DW | Initial y, signed, XYF fraction bits |
| z_i | input | ZW | Initial angle or linear accumulator, signed, ZF fraction bits |
| c_i | input | DW | Arcsine reference, same format as x and y |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| x_o | output | DW | Final x |
| y_o | output | DW | Final y |
| z_o | output | ZW | Final z |

## Verification
The bench goes after the z sign conventions first. A design that added the step angle in rotation and vectoring, or subtracted it in arcsine, would return −π/6 for a reference of 0.5 and z0 − y0/x0 in linear vectoring, and both show up as large z errors. Linear runs start near the ±2 convergence limit and near the edges of the representable range, which exposes a wrong linear constant table or a wrong shift. Restarts while busy and the interval after completion are also driven: a design that reloaded on a late start, or let its registers drift after done, would return wrong results or a shifted done pulse. lin_vec is toggled in the modes that must ignore it, to catch decode leakage into the circular and arcsine paths.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

   typedef enum logic [1:0] {
      MODE_CROT = 2'b00,
      MODE_CVEC = 2'b01,
      MODE_LIN  = 2'b10,
      MODE_ASIN = 2'b11
   } cordic_mode_e;

   // atan(2^-idx) scaled by 2^frac, rounded; evaluated at elaboration
   function automatic longint angle_fix(input int idx, input int frac);
      real t, t2, pw, acc, sc;
      t   = 1.0;
      sc  = 1.0;
      acc = 0.0;
      for (int k = 0; k < idx; k++) t = t / 2.0;
      for (int k = 0; k < frac; k++) sc = sc * 2.0;
      if (idx == 0) begin
         acc = 0.7853981633974483;
      end else begin
         t2 = t * t;
         pw = t;
         for (int k = 0; k < 24; k++) begin
            if (k % 2 == 0) acc = acc + pw / real'(2 * k + 1);
            else            acc = acc - pw / real'(2 * k + 1);
            pw = pw * t2;
         end
      end
      return longint'($rtoi(acc * sc + 0.5));
   endfunction

   // 2^-idx scaled by 2^frac
   function automatic longint lin_fix(input int idx, input int frac);
      if (idx > frac) return 64'sd0;
      return 64'sd1 <<< (frac - idx);
   endfunction

endpackage

// File: rtl/cordic_const_rom.sv
module cordic_const_rom
   import cordic_pkg::*;
#(
   parameter int ZW   = 16,
   parameter int ZF   = 13,
   parameter int ITER = 16,
   parameter int IW   = 4
) (
   input  logic [IW-1:0]        idx,
   input  logic                 linear,
   output logic signed [ZW-1:0] step_ang
);

   logic signed [ZW-1:0] circ_tab [ITER];
   logic signed [ZW-1:0] lin_tab  [ITER];

   for (genvar g = 0; g < ITER; g++) begin : g_tab
      localparam longint CIRC_V = angle_fix(g, ZF);
      localparam longint LIN_V  = lin_fix(g, ZF);
      assign circ_tab[g] = CIRC_V[ZW-1:0];
      assign lin_tab[g]  = LIN_V[ZW-1:0];
   end

   assign step_ang = linear ? lin_tab[idx] : circ_tab[idx];

endmodule

// File: rtl/cordic_decide.sv
module cordic_decide
   import cordic_pkg::*;
#(
   parameter int DW = 16,
   parameter int ZW = 16
) (
   input  cordic_mode_e         mode,
   input  logic                 lin_vec,
   input  logic signed [DW-1:0] y,
   input  logic signed [ZW-1:0] z,
   input  logic signed [DW-1:0] c,
   output logic                 ccw,
   output logic                 linear,
   output logic                 z_add
);

   // ccw = 1 turns (x,y) counter-clockwise this step.
   // Rotation/vectoring: z counts down the swept angle; arcsine: z counts it up.
   always_comb begin
      ccw    = 1'b0;
      linear = 1'b0;
      z_add  = 1'b0;
      unique case (mode)
         MODE_CROT: ccw = ~z[ZW-1];
         MODE_CVEC: ccw = y[DW-1];
         MODE_LIN: begin
            linear = 1'b1;
            ccw    = lin_vec ? y[DW-1] : ~z[ZW-1];
         end
         MODE_ASIN: begin
            ccw   = (y < c);
            z_add = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/cordic_step.sv
module cordic_step #(
   parameter int DW = 16,
   parameter int ZW = 16,
   parameter int SW = 4
) (
   input  logic signed [DW-1:0] x,
   input  logic signed [DW-1:0] y,
   input  logic signed [ZW-1:0] z,
   input  logic signed [ZW-1:0] step_ang,
   input  logic [SW-1:0]        shamt,
   input  logic                 ccw,
   input  logic                 linear,
   input  logic                 z_add,
   output logic signed [DW-1:0] nx,
   output logic signed [DW-1:0] ny,
   output logic signed [ZW-1:0] nz
);

   logic signed [DW-1:0] xs, ys;
   logic signed [ZW-1:0] sa;

   assign xs = x >>> shamt;
   assign ys = y >>> shamt;
   assign sa = ccw ? step_ang : -step_ang;

   always_comb begin
      if (linear)   nx = x;
      else if (ccw) nx = x - ys;
      else          nx = x + ys;
      ny = ccw ? (y + xs) : (y - xs);
      nz = z_add ? (z + sa) : (z - sa);
   end

endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
   import cordic_pkg::*;
#(
   parameter int DW   = 16,
   parameter int XYF  = DW - 3,
   parameter int ZW   = 16,
   parameter int ZF   = ZW - 3,
   parameter int ITER = DW
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [1:0]           mode_i,
   input  logic                 lin_vec_i,
   input  logic signed [DW-1:0] x_i,
   input  logic signed [DW-1:0] y_i,
   input  logic signed [ZW-1:0] z_i,
   input  logic signed [DW-1:0] c_i,
   output logic                 busy,
   output logic                 done,
   output logic signed [DW-1:0] x_o,
   output logic signed [DW-1:0] y_o,
   output logic signed [ZW-1:0] z_o
);

   localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;
   localparam logic [IW-1:0] LAST_IDX = IW'(ITER - 1);

   if (ITER < 2 || ITER > DW) begin : g_bad_iter
      $error("cordic_engine: ITER must lie in 2..DW");
   end
   if (XYF < 1 || XYF > DW - 3) begin : g_bad_xyf
      $error("cordic_engine: XYF leaves no integer headroom");
   end
   if (ZF < 1 || ZF > ZW - 3) begin : g_bad_zf
      $error("cordic_engine: ZF leaves no integer headroom");
   end

   logic signed [DW-1:0] x_q, y_q, c_q;
   logic signed [ZW-1:0] z_q;
   cordic_mode_e         mode_q;
   logic                 linv_q;
   logic                 busy_q, done_q;
   logic [IW-1:0]        cnt_q;

   logic                 ccw, linear, z_add;
   logic signed [ZW-1:0] step_ang;
   logic signed [DW-1:0] nx, ny;
   logic signed [ZW-1:0] nz;

   cordic_decide #(.DW(DW), .ZW(ZW)) u_decide (
      .mode    (mode_q),
      .lin_vec (linv_q),
      .y       (y_q),
      .z       (z_q),
      .c       (c_q),
      .ccw     (ccw),
      .linear  (linear),
      .z_add   (z_add)
   );

   cordic_const_rom #(.ZW(ZW), .ZF(ZF), .ITER(ITER), .IW(IW)) u_rom (
      .idx      (cnt_q),
      .linear   (linear),
      .step_ang (step_ang)
   );

   cordic_step #(.DW(DW), .ZW(ZW), .SW(IW)) u_step (
      .x        (x_q),
      .y        (y_q),
      .z        (z_q),
      .step_ang (step_ang),
      .shamt    (cnt_q),
      .ccw      (ccw),
      .linear   (linear),
      .z_add    (z_add),
      .nx       (nx),
      .ny       (ny),
      .nz       (nz)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q    <= '0;
         y_q    <= '0;
         z_q    <= '0;
         c_q    <= '0;
         mode_q <= MODE_CROT;
         linv_q <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (start) begin
               x_q    <= x_i;
               y_q    <= y_i;
               z_q    <= z_i;
               c_q    <= c_i;
               mode_q <= cordic_mode_e'(mode_i);
               linv_q <= lin_vec_i;
               cnt_q  <= '0;
               busy_q <= 1'b1;
            end
         end else begin
            x_q   <= nx;
            y_q   <= ny;
            z_q   <= nz;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign busy = busy_q;
   assign done = done_q;
   assign x_o  = x_q;
   assign y_o  = y_q;
   assign z_o  = z_q;

endmodule

// File: rtl/cordic_engine_chk.sv
module cordic_engine_chk #(
   parameter int DW   = 16,
   parameter int ZW   = 16,
   parameter int ITER = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic          busy,
   input logic          done,
   input logic [1:0]    mode_q,
   input logic [DW-1:0] x_o,
   input logic [DW-1:0] y_o,
   input logic [ZW-1:0] z_o
);

   int since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              since_q <= 0;
      else if (start && !busy) since_q <= 0;
      else if (busy)           since_q <= since_q + 1;
   end

   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3: a late start cannot stretch or restart the run
   assert_done_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> since_q == ITER);

   assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> since_q < ITER);

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(x_o) && $stable(y_o) && $stable(z_o)));

   assert_lin_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_q == 2'b10) |=> $stable(x_o));

endmodule

bind cordic_engine cordic_engine_chk #(.DW(DW), .ZW(ZW), .ITER(ITER)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start  (start),
   .busy   (busy),
   .done   (done),
   .mode_q (mode_q),
   .x_o    (x_o),
   .y_o    (y_o),
   .z_o    (z_o)
);

// File: tb/cordic_engine_tb.sv
module cordic_engine_tb;

   localparam int   CLK_PERIOD = 10;
   localparam int   ITER = 16;
   localparam real  ONE  = 8192.0;
   localparam int   NV   = 12;

   // mode, lin_vec, x, y, z, c (counts of 2^-13)
   localparam int VEC [NV][6] = '{
      '{0, 0, 4975,      0,   4289,     0},
      '{0, 0, 4975,      0,  -9830,     0},
      '{0, 0, 2487,   2487,   8192,     0},
      '{1, 0, 4096,   2458,      0,     0},
      '{1, 0, 3277,  -5734,   2048,     0},
      '{2, 0, 6144,   1024, -12288,     0},
      '{2, 0, 9830,      0,   4915,     0},
      '{2, 1, 6554,   4915,    819,     0},
      '{2, 1, 8192, -12288,      0,     0},
      '{3, 0, 4975,      0,      0,  4096},
      '{3, 0, 4975,      0,      0, -4096},
      '{3, 0, 4975,      0,      0,  6554}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [1:0]         mode_i = '0;
   logic               lin_vec_i = 1'b0;
   logic signed [15:0] x_i = '0, y_i = '0, z_i = '0, c_i = '0;
   logic               busy, done;
   logic signed [15:0] x_o, y_o, z_o;

   int  n_checks = 0;
   int  n_fail   = 0;
   real kg;

   always #(CLK_PERIOD / 2) clk = ~clk;

   cordic_engine u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .mode_i    (mode_i),
      .lin_vec_i (lin_vec_i),
      .x_i       (x_i),
      .y_i       (y_i),
      .z_i       (z_i),
      .c_i       (c_i),
      .busy      (busy),
      .done      (done),
      .x_o       (x_o),
      .y_o       (y_o),
      .z_o       (z_o)
   );

   task automatic chk_eq(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic chk_near(input string req, input string what, input int act,
                           input real exp_r, input int tol);
      real d;
      n_checks++;
      d = real'(act) - exp_r * ONE;
      if (d < 0.0) d = -d;
      if (d > real'(tol)) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, $rtoi(exp_r * ONE));
      end
   endtask

   task automatic set_ops(input int v, input logic lv_force);
      mode_i    = 2'(VEC[v][0]);
      lin_vec_i = VEC[v][1][0] | lv_force;
      x_i       = 16'(VEC[v][2]);
      y_i       = 16'(VEC[v][3]);
      z_i       = 16'(VEC[v][4]);
      c_i       = 16'(VEC[v][5]);
   endtask

   // start at a falling edge, return falling edges counted until done is seen
   task automatic run_op(input int v, input logic lv_force, output int lat);
      @(negedge clk);
      set_ops(v, lv_force);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic check_vec(input int v);
      real xr, yr, zr, cr;
      string rq;
      xr = real'(VEC[v][2]) / ONE;
      yr = real'(VEC[v][3]) / ONE;
      zr = real'(VEC[v][4]) / ONE;
      cr = real'(VEC[v][5]) / ONE;
      case (VEC[v][0])
         0: begin
            rq = "R5";
            chk_near(rq, "x", int'(x_o), kg * (xr * $cos(zr) - yr * $sin(zr)), 32);
            chk_near(rq, "y", int'(y_o), kg * (xr * $sin(zr) + yr * $cos(zr)), 32);
            chk_near(rq, "z", int'(z_o), 0.0, 32);
         end
         1: begin
            rq = "R6";
            chk_near(rq, "x", int'(x_o), kg * $sqrt(xr * xr + yr * yr), 32);
            chk_near(rq, "y", int'(y_o), 0.0, 32);
            chk_near(rq, "z", int'(z_o), zr + $atan(yr / xr), 32);
         end
         2: begin
            if (VEC[v][1] == 0) begin
               rq = "R7";
               chk_near(rq, "x", int'(x_o), xr, 0);
               chk_near(rq, "y", int'(y_o), yr + xr * zr, 32);
               chk_near(rq, "z", int'(z_o), 0.0, 32);
            end else begin
               rq = "R8";
               chk_near(rq, "y", int'(y_o), 0.0, 32);
               chk_near(rq, "z", int'(z_o), zr + yr / xr, 32);
            end
         end
         default: begin
            rq = "R9";
            chk_near(rq, "z", int'(z_o), zr + $asin(cr), 96);
         end
      endcase
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      int lat;
      int sx0, sy0, sz0, sz9;
      int hx, hy, hz;

      kg = 1.0;
      for (int i = 0; i < ITER; i++) kg = kg * $sqrt(1.0 + 1.0 / (4.0 ** i));

      // R1: reset state
      repeat (3) @(negedge clk);
      chk_eq("R1", "busy in reset", int'(busy), 0);
      chk_eq("R1", "done in reset", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1", "busy after reset", int'(busy), 0);
      chk_eq("R1", "x after reset", int'(x_o), 0);
      chk_eq("R1", "y after reset", int'(y_o), 0);
      chk_eq("R1", "z after reset", int'(z_o), 0);

      // main table, R5..R9
      sx0 = 0; sy0 = 0; sz0 = 0; sz9 = 0;
      for (int v = 0; v < NV; v++) begin
         run_op(v, 1'b0, lat);
         chk_eq("R2", "done latency", lat, ITER + 1);
         check_vec(v);
         if (v == 0) begin sx0 = int'(x_o); sy0 = int'(y_o); sz0 = int'(z_o); end
         if (v == 9) sz9 = int'(z_o);
      end

      // R9: reference +0.5 must give a positive angle
      chk_eq("R9", "asin(0.5) sign positive", int'(sz9 > 0), 1);

      // R2: busy during run, one-cycle done
      @(negedge clk);
      set_ops(3, 1'b0);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk_eq("R2", "busy after accept", int'(busy), 1);
      while (!done) @(negedge clk);
      chk_eq("R2", "busy at done", int'(busy), 0);
      hx = int'(x_o); hy = int'(y_o); hz = int'(z_o);
      @(negedge clk);
      chk_eq("R2", "done single cycle", int'(done), 0);

      // R4: outputs hold while idle with changing inputs
      set_ops(8, 1'b0);
      repeat (5) @(negedge clk);
      chk_eq("R4", "x held", int'(x_o), hx);
      chk_eq("R4", "y held", int'(y_o), hy);
      chk_eq("R4", "z held", int'(z_o), hz);

      // R3: start asserted while busy with other operands
      @(negedge clk);
      set_ops(0, 1'b0);
      start = 1'b1;
      @(negedge clk);
      set_ops(4, 1'b0);
      lat = 1;
      repeat (5) begin
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      while (!done && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      chk_eq("R3", "latency with late start", lat, ITER + 1);
      chk_eq("R3", "x unaffected", int'(x_o), sx0);
      chk_eq("R3", "y unaffected", int'(y_o), sy0);
      chk_eq("R3", "z unaffected", int'(z_o), sz0);

      // R10: lin_vec ignored outside mode 10
      run_op(0, 1'b1, lat);
      chk_eq("R10", "rotation x with lin_vec=1", int'(x_o), sx0);
      chk_eq("R10", "rotation z with lin_vec=1", int'(z_o), sz0);
      run_op(9, 1'b1, lat);
      chk_eq("R10", "arcsine z with lin_vec=1", int'(z_o), sz9);

      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

endmodule